// File: doc/BRIEF.md
# Reloading Timer Bank with Free-Running Timestamp

The block holds three down-counting interval timers and one wide up-counting timestamp. Each interval timer is programmed through a small write port: software stores a reload value, then sets a control byte that enables counting, picks between a periodic and a free-running wrap policy, and chooses between two tick-enable inputs. When an interval timer passes zero, it raises a sticky interrupt line. That line stays high until software writes the timer's clear address. Two of the interval timers are 16 bits wide and the third is 32 bits wide.

The timestamp is 40 bits wide. It advances on its own faster tick-enable input and is started and stopped by one enable bit. It has no interrupt. Software reads its lower 32 bits as a fine time reference, and the upper byte together with the enable bit from a second address.

Reads are combinational from the address. Writes take effect on the next rising clock edge. The clock and the tick pulses are produced outside the block. Each tick input is a one-cycle enable.

Top module: `tmr_bank`

## Requirements
- R1: After reset every counter, reload value, control byte, interrupt flag and the timestamp read as zero, and the timestamp is stopped.
- R2: A write to a timer's reload address stores the value, truncated to the timer's width, as the reload value and also loads it into the counter on the same edge, whether or not the timer is enabled. In that cycle the load takes priority over any tick.
- R3: Control bit 7 enables a timer. Control bit 3 selects the tick: 1 selects `tickMid` and 0 selects `tickSlow`. An enabled timer decrements by one on each cycle its selected tick is high. The other tick input has no effect, and a disabled timer holds its count.
- R4: When an enabled timer at zero receives its tick, it reloads from the reload value if control bit 6 is 1, which gives a period of reload+1 ticks. If control bit 6 is 0, it wraps to all ones of its width.
- R5: That zero-crossing sets the timer's `irq` bit (bit n for timer n). The bit stays set until any write to the timer's clear address. A clear in the same cycle as a zero-crossing leaves the bit set.
- R6: Timers 0 and 1 are 16 bits wide and timer 2 is 32 bits wide. Counter and reload reads are zero-extended to 32 bits.
- R7: The control read returns only bits 7, 6 and 3 of the last control write. All other bits read as zero.
- R8: The 40-bit timestamp adds one on each `tickFast` cycle while its enable is set, and holds otherwise. Bit 8 of a write to the high address sets the enable. The low address reads bits 31:0. The high address reads bits 39:32 in bits 7:0, with the enable in bit 8.
- R9: Address map: timer n (n = 0..2) uses 4n+0 for reload (read/write), 4n+1 for counter (read only), 4n+2 for control and 4n+3 for clear (reads zero). Address 12 is the timestamp low word and 13 is the timestamp high word. Other addresses read zero, and writes to read-only or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSlow | input | 1 | Slow tick enable for the interval timers |
| tickMid | input | 1 | Standard tick enable for the interval timers |
| tickFast | input | 1 | Tick enable for the timestamp |
| wrEn | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| irq | output | 3 | Sticky per-timer interrupt flags |

## Verification
The bench targets four corner cases:
- A clear written in the very cycle a timer at zero takes its tick. A design that ranks the clear first would drop an interrupt.
- A reload write landing together with a tick. A design that lets the tick win would count one past the new value or fire a spurious interrupt.
- The free-running wrap of a 16-bit timer. A wrong width would show 0xFFFFFFFF instead of 0xFFFF.
- The unselected tick input, and the write data bits above a timer's width. Either one leaking through would disturb the count.

Long stretches of random writes and ticks are compared every cycle against a behavioural model, including writes to read-only and unmapped addresses, which must leave every readback unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR = 3;
  localparam int ADDR_W = 4;
  localparam int CTRL_EN = 7;
  localparam int CTRL_PER = 6;
  localparam int CTRL_MID = 3;
  localparam logic [7:0] CTRL_MASK = 8'hC8;
  localparam int STAMP_EN_BIT = 8;
  localparam logic [1:0] OFS_LOAD = 2'd0;
  localparam logic [1:0] OFS_VAL = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_CLR = 2'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAMP_LO = 4'd12;
  localparam logic [ADDR_W-1:0] ADDR_STAMP_HI = 4'd13;

  typedef struct packed {
    logic [NUM_TMR-1:0] loadWr;
    logic [NUM_TMR-1:0] ctrlWr;
    logic [NUM_TMR-1:0] clrWr;
    logic stampWr;
  } strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  logic [1:0] slot;
  logic [1:0] ofs;

  assign slot = addr[ADDR_W-1:2];
  assign ofs = addr[1:0];

  always_comb begin
    stb = '0;
    if (wrEn) begin
      if (int'(slot) < NUM_TMR) begin
        unique case (ofs)
          OFS_LOAD: stb.loadWr[slot] = 1'b1;
          OFS_CTRL: stb.ctrlWr[slot] = 1'b1;
          OFS_CLR:  stb.clrWr[slot] = 1'b1;
          default:  ;
        endcase
      end else if (addr == ADDR_STAMP_HI) begin
        stb.stampWr = 1'b1;
      end
    end
  end

  // R9: a single write never strobes more than one register
  always_comb begin
    a_r9_one_strobe: assert ($onehot0(stb));
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickSlow,
  input  logic         tickMid,
  input  logic         loadWr,
  input  logic         ctrlWr,
  input  logic         clrWr,
  input  logic [W-1:0] loadIn,
  input  logic [7:0]   ctrlIn,
  output logic [W-1:0] count,
  output logic [W-1:0] reload,
  output logic [7:0]   ctrl,
  output logic         irq
);
  logic tick;
  logic run;
  logic atZero;
  logic fire;

  assign tick = ctrl[CTRL_MID] ? tickMid : tickSlow;
  assign run = ctrl[CTRL_EN] & tick;
  assign atZero = (count == '0);
  assign fire = run & atZero & ~loadWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      reload <= '0;
      ctrl <= '0;
      irq <= 1'b0;
    end else begin
      if (loadWr) begin
        reload <= loadIn;
        count <= loadIn;
      end else if (run) begin
        if (atZero) count <= ctrl[CTRL_PER] ? reload : '1;
        else count <= count - 1'b1;
      end
      if (ctrlWr) ctrl <= ctrlIn & CTRL_MASK;
      if (fire) irq <= 1'b1;
      else if (clrWr) irq <= 1'b0;
    end
  end

  // R3: a disabled timer with no load write keeps its count
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl[CTRL_EN] && !loadWr) |=> $stable(count));

  // R4: periodic zero-crossing reloads from the reload value
  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl[CTRL_EN] && ctrl[CTRL_PER] && tick && atZero && !loadWr) |=> (count == $past(reload)));

  // R5: the flag only rises after the counter stood at zero
  a_r5_rise_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(count) == '0));

  // R5: the flag is sticky without a clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrWr) |=> irq);

  // R5: a clear while the counter is away from zero drops the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !atZero) |=> !irq);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W = 32,
  parameter int STAMP_W = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickSlow,
  input  logic               tickMid,
  input  logic               tickFast,
  input  strobe_t            stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_TMR-1:0] irq
);
  localparam int SLOTS = 2 ** (ADDR_W - 2);

  logic [DATA_W-1:0] valRd [SLOTS];
  logic [DATA_W-1:0] loadRd [SLOTS];
  logic [7:0] ctrlRd [SLOTS];
  logic [STAMP_W-1:0] stamp;
  logic stampEn;

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    if (g < NUM_TMR) begin : gTmr
      localparam int W = (g == NUM_TMR - 1) ? WIDE_W : NARROW_W;
      logic [W-1:0] cnt;
      logic [W-1:0] rld;
      tmr_unit #(.W(W)) u_unit (
        .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickMid(tickMid),
        .loadWr(stb.loadWr[g]), .ctrlWr(stb.ctrlWr[g]), .clrWr(stb.clrWr[g]),
        .loadIn(wrData[W-1:0]), .ctrlIn(wrData[7:0]),
        .count(cnt), .reload(rld), .ctrl(ctrlRd[g]), .irq(irq[g])
      );
      assign valRd[g] = DATA_W'(cnt);
      assign loadRd[g] = DATA_W'(rld);
    end else begin : gEmpty
      assign valRd[g] = '0;
      assign loadRd[g] = '0;
      assign ctrlRd[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stamp <= '0;
      stampEn <= 1'b0;
    end else begin
      if (stampEn && tickFast) stamp <= stamp + 1'b1;
      if (stb.stampWr) stampEn <= wrData[STAMP_EN_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    if (int'(addr[ADDR_W-1:2]) < NUM_TMR) begin
      unique case (addr[1:0])
        OFS_LOAD: rdData = loadRd[addr[ADDR_W-1:2]];
        OFS_VAL:  rdData = valRd[addr[ADDR_W-1:2]];
        OFS_CTRL: rdData = DATA_W'(ctrlRd[addr[ADDR_W-1:2]]);
        default:  rdData = '0;
      endcase
    end else if (addr == ADDR_STAMP_LO) begin
      rdData = stamp[DATA_W-1:0];
    end else if (addr == ADDR_STAMP_HI) begin
      rdData = DATA_W'(stamp[STAMP_W-1:DATA_W]);
      rdData[STAMP_EN_BIT] = stampEn;
    end
  end

  // R8: a stopped timestamp holds its value
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stampEn |=> $stable(stamp));

  // R8: a running timestamp steps by exactly one per fast tick
  a_r8_step: assert property (@(posedge clk) disable iff (!rstN)
    (stampEn && tickFast) |=> (stamp == $past(stamp) + 1'b1));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W = 32,
  parameter int STAMP_W = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickSlow,
  input  logic               tickMid,
  input  logic               tickFast,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_TMR-1:0] irq
);
  strobe_t stb;

  tmr_ctrl u_ctrl (
    .wrEn(wrEn), .addr(addr), .stb(stb)
  );

  tmr_datapath #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .STAMP_W(STAMP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickMid(tickMid),
    .tickFast(tickFast), .stb(stb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickSlow = 1'b0, tickMid = 1'b0, tickFast = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0] irq;

  always #(PERIOD/2) clk = ~clk;

  tmr_bank u_tmr_bank (
    .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickMid(tickMid),
    .tickFast(tickFast), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  int nVec = 0;
  int nBad = 0;

  // behavioural reference state
  longint mCnt[3], mLd[3], mMask[3];
  int mCtl[3];
  bit mIrq[3];
  longint mStamp;
  bit mSen;

  function automatic longint mRead(int a);
    if (a < 12) begin
      case (a % 4)
        0: return mLd[a/4];
        1: return mCnt[a/4];
        2: return longint'(mCtl[a/4]);
        default: return 0;
      endcase
    end
    if (a == 12) return mStamp & 64'hFFFF_FFFF;
    if (a == 13) return (mStamp >> 32) | (mSen ? 64'h100 : 64'h0);
    return 0;
  endfunction

  task automatic step(string tag, bit we, int a, longint d, bit ts, bit tm, bit tf);
    longint exp;
    wrEn = we; addr = a[3:0]; wrData = d[31:0];
    tickSlow = ts; tickMid = tm; tickFast = tf;
    #1;
    nVec++;
    exp = mRead(a);
    if (rdData !== exp[31:0]) begin
      nBad++;
      $display("FAIL %s addr=%0d rdData=%h expected=%h", tag, a, rdData, exp[31:0]);
    end
    for (int t = 0; t < 3; t++) begin
      if (irq[t] !== mIrq[t]) begin
        nBad++;
        $display("FAIL R5 irq[%0d]=%b expected=%b", t, irq[t], mIrq[t]);
      end
    end
    @(posedge clk);
    for (int t = 0; t < 3; t++) begin
      bit lw, cw, clw, tick, run, fire;
      lw = we && a < 12 && a / 4 == t && a % 4 == 0;
      cw = we && a < 12 && a / 4 == t && a % 4 == 2;
      clw = we && a < 12 && a / 4 == t && a % 4 == 3;
      tick = ((mCtl[t] & 8) != 0) ? tm : ts;
      run = ((mCtl[t] & 128) != 0) && tick;
      fire = run && mCnt[t] == 0 && !lw;
      if (lw) begin
        mLd[t] = d & mMask[t];
        mCnt[t] = d & mMask[t];
      end else if (run) begin
        if (mCnt[t] == 0) mCnt[t] = ((mCtl[t] & 64) != 0) ? mLd[t] : mMask[t];
        else mCnt[t] = mCnt[t] - 1;
      end
      if (cw) mCtl[t] = int'(d) & 'hC8;
      if (fire) mIrq[t] = 1'b1;
      else if (clw) mIrq[t] = 1'b0;
    end
    if (mSen && tf) mStamp = (mStamp + 1) & 64'hFF_FFFF_FFFF;
    if (we && a == 13) mSen = d[8];
    @(negedge clk);
  endtask

  task automatic wr(string tag, int a, longint d);
    step(tag, 1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(string tag, int a);
    step(tag, 1'b0, a, 0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    mMask[0] = 64'hFFFF; mMask[1] = 64'hFFFF; mMask[2] = 64'hFFFF_FFFF;
    for (int t = 0; t < 3; t++) begin
      mCnt[t] = 0; mLd[t] = 0; mCtl[t] = 0; mIrq[t] = 0;
    end
    mStamp = 0; mSen = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state on every address
    for (int a = 0; a < 16; a++) rd("R1", a);

    // R7 / R2: timer 0 setup, control readback masked
    wr("R7", 2, 64'h48);
    rd("R7", 2);
    wr("R2", 0, 64'h4);
    rd("R2", 0);
    rd("R2", 1);
    wr("R7", 2, 64'hFF);
    rd("R7", 2);
    wr("R7", 2, 64'hC8);
    // R4: periodic count with reload, period load+1
    for (int i = 0; i < 12; i++) step("R4", 1'b0, 1, 0, 1'b0, 1'b1, 1'b0);
    // R3: slow tick ignored when the mid tick is selected
    for (int i = 0; i < 4; i++) step("R3", 1'b0, 1, 0, 1'b1, 1'b0, 1'b0);
    // R5: clear drops the sticky flag
    wr("R5", 3, 64'h0);
    rd("R5", 1);
    // R5: clear together with a zero-crossing keeps the flag
    wr("R2", 0, 64'h0);
    step("R5", 1'b1, 3, 64'h1, 1'b0, 1'b1, 1'b0);
    rd("R5", 1);
    // R2: reload write while running wins over the tick
    step("R2", 1'b1, 0, 64'h9, 1'b0, 1'b1, 1'b0);
    rd("R2", 1);
    step("R2", 1'b0, 1, 0, 1'b0, 1'b1, 1'b0);
    // R6: narrow truncation
    wr("R6", 0, 64'hABCD_1234);
    rd("R6", 0);
    wr("R7", 2, 64'h0);
    wr("R5", 3, 64'h0);

    // R4: timer 1 free-running wrap to 0xFFFF
    wr("R4", 6, 64'h88);
    wr("R4", 4, 64'h2);
    for (int i = 0; i < 5; i++) step("R4", 1'b0, 5, 0, 1'b0, 1'b1, 1'b0);
    // R3: disabled timer holds
    wr("R3", 6, 64'h0);
    for (int i = 0; i < 3; i++) step("R3", 1'b0, 5, 0, 1'b1, 1'b1, 1'b0);
    wr("R5", 7, 64'h0);

    // R6: wide timer keeps 32 bits
    wr("R6", 8, 64'hDEAD_BEEF);
    rd("R6", 8);
    rd("R6", 9);
    // R3: timer 2 on the slow tick, mid tick ignored
    wr("R3", 10, 64'hC0);
    wr("R3", 8, 64'h2);
    for (int i = 0; i < 10; i++) step("R3", 1'b0, 9, 0, i[0], ~i[0], 1'b0);
    wr("R5", 11, 64'h0);
    wr("R3", 10, 64'h0);

    // R8: timestamp enable, count and hold
    wr("R8", 13, 64'h100);
    rd("R8", 13);
    for (int i = 0; i < 20; i++) step("R8", 1'b0, 12, 0, 1'b0, 1'b0, i % 3 != 0);
    rd("R8", 13);
    wr("R8", 13, 64'h0);
    for (int i = 0; i < 5; i++) step("R8", 1'b0, 12, 0, 1'b0, 1'b0, 1'b1);

    // R9: writes to read-only and unmapped addresses change nothing
    wr("R9", 1, 64'h5555);
    wr("R9", 12, 64'hFFFF_FFFF);
    wr("R9", 15, 64'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) rd("R9", a);

    // R9: random traffic against the model
    for (int i = 0; i < 600; i++) begin
      int a;
      bit we;
      longint d;
      a = int'($urandom_range(0, 15));
      we = ($urandom_range(0, 5) == 0);
      d = longint'($urandom());
      if ($urandom_range(0, 1) == 0) d = d & 64'h1C8;
      step("R9", we, a, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule